// File: doc/BRIEF.md
# Paged Audio Controller Register File

This block is the register window of a three-channel audio controller with two playback channels and one capture channel. A host reaches it through a 64-word, 256-byte space over a simple synchronous bus. Each access names a word address and a four-bit byte-enable pattern. That pattern selects a byte, halfword or word access, and the data sits on its natural byte lanes. Control and serial-control writes of less than a word merge into the 32-bit registers. The other registers accept only the access sizes that suit them.

Offsets 0x30 to 0x3F form a paged sub-window. The value in the page register is placed above the offset to reach banked per-channel DMA registers: a frame address and a frame count for each channel. The block also keeps per-channel interrupt-pending flags. The audio datapath raises these through event pulses, and the block reports them in the status register and on one interrupt line. When software turns a channel's interrupt enable off, that channel's pending flag is cleared.

Top module: `audio_regwin`

## Requirements
- R1: After reset, control reads 0x00000001, status reads 0x00000060, and page, codec, serial control, sample counts and the banked DMA registers read 0.
- R2: Access size comes from the byte-enable pattern. One bit set is a byte access, 0011 or 1100 is a halfword access (low or high half), and 1111 is a word access. Any other pattern is unmapped.
- R3: A byte or halfword write to control at 0x00 replaces only the enabled lanes. A byte write to serial control at 0x20 does the same. A word write replaces the whole register.
- R4: For offsets 0x30 to 0x3F, the effective address is {page, offset}. Page 0x0C maps 0x30/0x34 to playback-1 frame address and count, and 0x38/0x3C to playback-2 frame address and count. Page 0x0D maps 0x30/0x34 to capture frame address and count. Page 0x0D offsets 0x38/0x3C, and every other page, are unmapped. A word write to the page register at 0x0C keeps only bits 3:0. A byte write on lane 0 keeps all 8 bits.
- R5: Status bit 31 and the irq output are 1 exactly when any pending bit is set. The pending bits are status bit 2 for playback 1, bit 1 for playback 2 and bit 0 for capture. Status bits 6:5 read 11, and all other status bits read 0.
- R6: An event pulse on evt[k] sets pending status bit k only if that channel's enable is set. The enables are serial-control bit 8 for playback 1 (status bit 2), bit 9 for playback 2 (status bit 1) and bit 10 for capture (status bit 0).
- R7: A write that takes an enable from 1 to 0 clears that channel's pending bit. This clear wins over an event pulse for that channel in the same cycle.
- R8: Unmapped reads return all ones on the enabled lanes. A byte read of 0x1B returns 5. A halfword read of control is unmapped.
- R9: Writes to unmapped offsets or with unsupported sizes change no register and no pending flag. This includes status, a word write to codec, and paged offsets outside the banked map.
- R10: A word write, or a low-half write, to a sample-count register updates its low 16 bits. The sample-count registers are at 0x24 for playback 1, 0x28 for playback 2 and 0x2C for capture. A word read returns {16'h0, count}. A high-half read returns 0.
- R11: A low-half write to codec at 0x10 stores 16 bits, and a word read returns them zero-extended.
- R12: rvalid is high in the cycle after a read strobe. rdata then carries the addressed bytes on their own lanes, with disabled lanes zero.
- R13: A frame count can be read as a word or as either halfword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wa | input | 6 | Word address (byte offset bits 7:2) |
| be | input | 4 | Byte enables, bit n = lane n |
| wdata | input | 32 | Write data on byte lanes |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| evt | input | 3 | Channel completion pulses (bit 2 playback 1, bit 1 playback 2, bit 0 capture) |
| rdata | output | 32 | Read data, valid with rvalid |
| rvalid | output | 1 | Read data valid, one cycle after rd |
| irq | output | 1 | OR of pending channel interrupts |

## Verification
The bench pushes merged partial writes through control and serial control. A design that applied a byte write to the whole register, or treated sparse byte-enable patterns as writes, shows a wrong read-back.

It moves the page register between banks. It checks that a 32-bit page write drops the upper nibble, that the phantom slots read all ones, and that writes outside the page map leave the banks untouched.

On the interrupt side, it checks that an event with the enable off does nothing, that disabling an enable clears its flag even when an event arrives in the same cycle, and that irq drops only when the last flag goes.

// File: rtl/audio_regwin.sv
module audio_regwin #(
  parameter int CNT_W = 16,
  parameter int NCH   = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  wa,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  input  logic        wr,
  input  logic        rd,
  input  logic [2:0]  evt,
  output logic [31:0] rdata,
  output logic        rvalid,
  output logic        irq
);
  localparam logic [15:0] A_CTL = 16'h0000, A_STAT = 16'h0004, A_PAGE = 16'h000C,
                          A_CODEC = 16'h0010, A_SCTL = 16'h0020, A_LEG = 16'h0018;

  function automatic logic [15:0] cnt_addr(int i);
    return 16'h0024 + 16'(i * 4);
  endfunction
  function automatic logic [15:0] fa_addr(int i);
    return (i < 2) ? 16'h0C30 + 16'(i * 8) : 16'h0D30;
  endfunction

  logic [31:0] ctl_q, sctl_q, sctl_n;
  logic [2:0]  pend_q, pend_n, en_old, en_new;
  logic        intr_q;
  logic [7:0]  page_q;
  logic [15:0] codec_q;
  logic [CNT_W-1:0] scnt_q [NCH];
  logic [31:0] fadr_q [NCH];
  logic [31:0] fcnt_q [NCH];

  wire         sz_b = $onehot(be);
  wire         sz_lo = (be == 4'b0011);
  wire         sz_hi = (be == 4'b1100);
  wire         sz_w = (be == 4'b1111);
  wire [31:0]  m = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  wire         in_win = (wa[5:2] == 4'h3);
  wire [15:0]  ew = {in_win ? page_q : 8'h00, wa, 2'b00};

  wire ctl_we  = wr && ew == A_CTL && (sz_b || sz_lo || sz_hi || sz_w);
  wire sctl_we = wr && ew == A_SCTL && (sz_b || sz_w);

  assign sctl_n = sctl_we ? ((sctl_q & ~m) | (wdata & m)) : sctl_q;
  assign en_old = {sctl_q[8], sctl_q[9], sctl_q[10]};
  assign en_new = {sctl_n[8], sctl_n[9], sctl_n[10]};
  assign pend_n = (pend_q | (evt & en_new)) & ~(en_old & ~en_new);

  wire [31:0] stat_w = {intr_q, 24'h0, 2'b11, 2'b00, pend_q};

  logic        rd_hit;
  logic [31:0] rd_word;
  always_comb begin
    rd_hit  = 1'b0;
    rd_word = '0;
    if (sz_b) begin
      if (ew == A_CTL)                   begin rd_hit = 1'b1; rd_word = ctl_q; end
      else if (ew == A_STAT)             begin rd_hit = 1'b1; rd_word = stat_w; end
      else if (ew == A_PAGE && be[0])    begin rd_hit = 1'b1; rd_word = {24'h0, page_q}; end
      else if (ew == A_LEG && be[3])     begin rd_hit = 1'b1; rd_word = 32'h0500_0000; end
    end
    if (sz_w) begin
      if (ew == A_CTL)        begin rd_hit = 1'b1; rd_word = ctl_q; end
      else if (ew == A_STAT)  begin rd_hit = 1'b1; rd_word = stat_w; end
      else if (ew == A_PAGE)  begin rd_hit = 1'b1; rd_word = {24'h0, page_q}; end
      else if (ew == A_CODEC) begin rd_hit = 1'b1; rd_word = {16'h0, codec_q}; end
      else if (ew == A_SCTL)  begin rd_hit = 1'b1; rd_word = sctl_q; end
    end
    for (int i = 0; i < NCH; i++) begin
      if (ew == cnt_addr(i) && (sz_w || sz_hi)) begin
        rd_hit = 1'b1; rd_word = 32'(scnt_q[i]);
      end
      if (ew == fa_addr(i) && sz_w) begin
        rd_hit = 1'b1; rd_word = fadr_q[i];
      end
      if (ew == fa_addr(i) + 16'h4 && (sz_w || sz_lo || sz_hi)) begin
        rd_hit = 1'b1; rd_word = fcnt_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q   <= 32'h1;
      sctl_q  <= '0;
      pend_q  <= '0;
      intr_q  <= 1'b0;
      page_q  <= '0;
      codec_q <= '0;
      rvalid  <= 1'b0;
      rdata   <= '0;
      for (int i = 0; i < NCH; i++) begin
        scnt_q[i] <= '0;
        fadr_q[i] <= '0;
        fcnt_q[i] <= '0;
      end
    end else begin
      if (ctl_we) ctl_q <= (ctl_q & ~m) | (wdata & m);
      sctl_q <= sctl_n;
      pend_q <= pend_n;
      intr_q <= |pend_n;
      if (wr && ew == A_PAGE && sz_w) page_q <= {4'h0, wdata[3:0]};
      if (wr && ew == A_PAGE && sz_b && be[0]) page_q <= wdata[7:0];
      if (wr && ew == A_CODEC && sz_lo) codec_q <= wdata[15:0];
      for (int i = 0; i < NCH; i++) begin
        if (wr && ew == cnt_addr(i) && (sz_w || sz_lo)) scnt_q[i] <= wdata[CNT_W-1:0];
        if (wr && ew == fa_addr(i) && sz_w) fadr_q[i] <= wdata;
        if (wr && ew == fa_addr(i) + 16'h4 && sz_w) fcnt_q[i] <= wdata;
      end
      rvalid <= rd;
      if (rd) rdata <= (rd_hit ? rd_word : 32'hFFFF_FFFF) & m;
    end
  end

  assign irq = intr_q;

  a_r5_irq_or: assert property (@(posedge clk) disable iff (!rst_n) irq == |pend_q);
  a_r7_clear_pb1: assert property (@(posedge clk) disable iff (!rst_n) $fell(sctl_q[8]) |-> !pend_q[2]);
  a_r7_clear_pb2: assert property (@(posedge clk) disable iff (!rst_n) $fell(sctl_q[9]) |-> !pend_q[1]);
  a_r7_clear_cap: assert property (@(posedge clk) disable iff (!rst_n) $fell(sctl_q[10]) |-> !pend_q[0]);
  a_r4_page_word: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wa == 6'h03 && be == 4'hF) |=> page_q[7:4] == 4'h0);
  a_r3_lane_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wa == 6'h00 && be == 4'b0001) |=> ctl_q[31:8] == $past(ctl_q[31:8]));
  a_r9_stat_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wa == 6'h01 && evt == 3'b000) |=> pend_q == $past(pend_q));
  a_r12_rvalid: assert property (@(posedge clk) disable iff (!rst_n) rd |=> rvalid);
endmodule

// File: tb/tb_audio_regwin.sv
module tb_audio_regwin;
  logic clk = 1'b0, rst_n = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [5:0] wa = '0;
  logic [3:0] be = '0;
  logic [31:0] wdata = '0;
  logic [2:0] evt = '0;
  logic [31:0] rdata;
  logic rvalid, irq;
  int errors = 0, checks = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  audio_regwin dut (.clk(clk), .rst_n(rst_n), .wa(wa), .be(be), .wdata(wdata),
                    .wr(wr), .rd(rd), .evt(evt), .rdata(rdata), .rvalid(rvalid), .irq(irq));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wrt(input logic [5:0] a, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk); wa = a; be = b; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rdx(input logic [5:0] a, input logic [3:0] b, input logic [31:0] e, input string tag);
    @(negedge clk); wa = a; be = b; rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic pulse(input logic [2:0] v);
    @(negedge clk); evt = v;
    @(negedge clk); evt = '0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) check(1'b0, "R12 unexpected rvalid", rdata, 32'h0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        check(rdata === e, t, rdata, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 32'h0, 32'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(irq === 1'b0 && rvalid === 1'b0, "R1 irq/rvalid reset", {30'h0, irq, rvalid}, 32'h0);
    rdx(6'h00, 4'hF, 32'h0000_0001, "R1 ctl reset");
    rdx(6'h01, 4'hF, 32'h0000_0060, "R1 status reset");
    rdx(6'h03, 4'hF, 32'h0, "R1 page reset");
    rdx(6'h04, 4'hF, 32'h0, "R1 codec reset");
    rdx(6'h08, 4'hF, 32'h0, "R1 sctl reset");
    rdx(6'h09, 4'hF, 32'h0, "R1 scount reset");
    // R3 merge
    wrt(6'h00, 4'hF, 32'h1234_5678);
    wrt(6'h00, 4'b0010, 32'h0000_AB00);
    rdx(6'h00, 4'hF, 32'h1234_AB78, "R3 ctl byte merge");
    wrt(6'h00, 4'b1100, 32'hCAFE_0000);
    rdx(6'h00, 4'hF, 32'hCAFE_AB78, "R3 ctl half merge");
    rdx(6'h00, 4'b0100, 32'h00FE_0000, "R12 lane only");
    // R2 sparse pattern ignored
    wrt(6'h00, 4'b0101, 32'hFFFF_FFFF);
    rdx(6'h00, 4'hF, 32'hCAFE_AB78, "R2 sparse write ignored");
    rdx(6'h00, 4'b0101, 32'h00FF_00FF, "R2 sparse read unmapped");
    // R8
    rdx(6'h00, 4'b0011, 32'h0000_FFFF, "R8 ctl half read");
    rdx(6'h06, 4'b1000, 32'h0500_0000, "R8 byte 0x1B");
    rdx(6'h10, 4'hF, 32'hFFFF_FFFF, "R8 unmapped word");
    rdx(6'h03, 4'b0010, 32'h0000_FF00, "R8 page lane1");
    // R6/R5/R7 interrupts
    wrt(6'h08, 4'b0010, 32'h0000_0700);
    rdx(6'h08, 4'hF, 32'h0000_0700, "R3 sctl byte");
    pulse(3'b111);
    check(irq === 1'b1, "R5 irq set", {31'h0, irq}, 32'h1);
    rdx(6'h01, 4'hF, 32'h8000_0067, "R6 all pending");
    wrt(6'h08, 4'hF, 32'h0000_0600);
    rdx(6'h01, 4'hF, 32'h8000_0063, "R7 clear pb1");
    @(negedge clk); wa = 6'h08; be = 4'b0010; wdata = 32'h0000_0200; wr = 1'b1; evt = 3'b001;
    @(negedge clk); wr = 1'b0; evt = '0;
    rdx(6'h01, 4'hF, 32'h8000_0062, "R7 clear wins");
    pulse(3'b101);
    rdx(6'h01, 4'hF, 32'h8000_0062, "R6 disabled event ignored");
    check(irq === 1'b1, "R5 irq held", {31'h0, irq}, 32'h1);
    wrt(6'h01, 4'hF, 32'hFFFF_FFFF);
    rdx(6'h01, 4'hF, 32'h8000_0062, "R9 status write ignored");
    wrt(6'h08, 4'b0010, 32'h0);
    check(irq === 1'b0, "R5 irq drop", {31'h0, irq}, 32'h0);
    rdx(6'h01, 4'b1000, 32'h0, "R5 status byte3");
    // R4 paging
    wrt(6'h03, 4'hF, 32'hFFFF_FFFC);
    rdx(6'h03, 4'hF, 32'h0000_000C, "R4 page word 4 bits");
    wrt(6'h03, 4'b0001, 32'h0000_00AB);
    rdx(6'h03, 4'b0001, 32'h0000_00AB, "R4 page byte 8 bits");
    wrt(6'h03, 4'hF, 32'h0000_000C);
    wrt(6'h0C, 4'hF, 32'h1111_0000);
    wrt(6'h0D, 4'hF, 32'h0005_0003);
    wrt(6'h0E, 4'hF, 32'h2222_0000);
    wrt(6'h0F, 4'hF, 32'h0007_0009);
    wrt(6'h03, 4'hF, 32'h0000_000D);
    wrt(6'h0C, 4'hF, 32'h3333_0000);
    wrt(6'h0D, 4'hF, 32'h0001_0002);
    wrt(6'h0E, 4'hF, 32'h5555_5555);
    rdx(6'h0E, 4'hF, 32'hFFFF_FFFF, "R4 phantom");
    rdx(6'h0C, 4'hF, 32'h3333_0000, "R4 cap addr");
    rdx(6'h0D, 4'b1100, 32'h0001_0000, "R13 cnt hi");
    rdx(6'h0D, 4'b0011, 32'h0000_0002, "R13 cnt lo");
    wrt(6'h03, 4'hF, 32'h0);
    rdx(6'h0C, 4'hF, 32'hFFFF_FFFF, "R8 page0 window");
    wrt(6'h0C, 4'hF, 32'h9999_9999);
    wrt(6'h03, 4'hF, 32'h0000_000C);
    rdx(6'h0C, 4'hF, 32'h1111_0000, "R9 page0 write ignored");
    rdx(6'h0F, 4'hF, 32'h0007_0009, "R4 pb2 count");
    rdx(6'h0E, 4'hF, 32'h2222_0000, "R4 pb2 addr");
    rdx(6'h0D, 4'hF, 32'h0005_0003, "R13 pb1 count word");
    // R10 sample counts
    wrt(6'h09, 4'hF, 32'hDEAD_1234);
    rdx(6'h09, 4'hF, 32'h0000_1234, "R10 scount word");
    wrt(6'h0A, 4'b0011, 32'h0000_5678);
    rdx(6'h0A, 4'hF, 32'h0000_5678, "R10 scount half");
    rdx(6'h0B, 4'b1100, 32'h0000_0000, "R10 scount hi");
    // R11 codec
    wrt(6'h04, 4'b0011, 32'h0000_BEEF);
    rdx(6'h04, 4'hF, 32'h0000_BEEF, "R11 codec");
    wrt(6'h04, 4'hF, 32'h1111_1111);
    rdx(6'h04, 4'hF, 32'h0000_BEEF, "R9 codec word ignored");
    repeat (3) @(negedge clk);
    check(rvalid === 1'b0, "R12 idle rvalid", {31'h0, rvalid}, 32'h0);
    check(exp_q.size() == 0, "R12 all reads returned", exp_q.size(), 32'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule